// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block computes the architectural state change a processor core makes when it takes an exception, and the matching change when a handler returns. On a one-cycle `takeExc` strobe it reads the exception kind, a program-check sub-cause, the current status word (MSR), the current instruction address, the vector table entry for the exception and a global vector prefix. One clock edge later it commits the new state:
- a return address and a saved status are written into one of four save-register pairs;
- a new MSR is produced;
- the next fetch address is formed from the vector and the prefix.

A separate one-cycle `rfiStrobe` restores the fetch address and MSR from a chosen save pair. The restored status passes through a mask that depends on the pair and the exception model. The two strobes are never raised together.

The block has two exception models, chosen by `embMode`. The embedded model saves the MSR unmasked, sends critical-class exceptions to their own save pairs, and duplicates machine-check and debug state into the critical pair. In the classic model the must-be-zero field is cleared and every exception uses the normal pair.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rstN` is low, and after it is released, `msrOut` is 0, `pcOut` is the `RESET_PC` parameter (default 0x100), `commit`, `vecErr` and `halted` are 0, and all eight save registers are 0.
- R2: Exception codes on `excCode`: 1 critical, 2 machine check, 3 data storage, 4 instruction storage, 5 external, 6 alignment, 7 program, 8 FP unavailable, 9 system call, 10 auxiliary unavailable, 11 decrementer, 12 fixed timer, 13 watchdog, 14 debug, 15 reset, 16 vector unavailable, 17 to 31 generic. A taken exception whose vector is not all ones raises `commit` for exactly the following cycle and sets `pcOut` to `vecEntry | vecPrefix`. `takeExc` and `rfiStrobe` are never high together.
- R3: A taken exception whose `vecEntry` is 0xFFFFFFFF raises `vecErr` for one cycle. It does not raise `commit`, and it leaves the MSR, the fetch address, the save pairs and `halted` unchanged.
- R4: The saved status is `curMsr & ~0x783F0000` in the classic model (`embMode`=0) and `curMsr` unmasked in the embedded model. Any cause bits are ORed in after masking.
- R5: The new MSR after an entry has every bit clear except two. Bit 12 (machine-check enable) is copied from `curMsr`. Bit 0 (little-endian) is set when `curMsr` bit 16 (interrupt little-endian) is set.
- R6: Alignment, program, FP-unavailable, auxiliary-unavailable and vector-unavailable exceptions save `curPc - 4`. Every other exception saves `curPc`.
- R7: Program exceptions set a saved-status cause bit selected by `subCode`: 0 (FP) sets 0x00100000, 1 (illegal) sets 0x00080000, 2 (privileged) sets 0x00040000, 3 (trap) sets 0x00020000.
- R8: An FP program exception (`subCode` 0) is dropped when MSR bit 13 (FP enable) is 0, or when MSR bits 11 and 8 (FP modes) are both 0. A dropped exception produces no `commit`, no `vecErr` and no state change, even with an all-ones vector. When the two mode bits differ, 0x00010000 is also set and `curPc - 4` is saved. When both mode bits are 1, `curPc` is saved.
- R9: A taken machine check clears bit 12 in the new MSR. If `curMsr` bit 12 was 0, `halted` is set, and it stays set until reset.
- R10: Save pairs are 0 normal, 1 critical, 2 machine check and 3 debug. In the embedded model, critical and watchdog exceptions save into pair 1. Machine check saves into pair 2 and debug into pair 3, and both also copy the same values into pair 1. In the classic model, and for every other exception, the save goes to pair 0.
- R11: A reset exception taken with `curMsr` bit 18 (power-save) set ORs 0x00010000 into the saved status. Without that bit, machine-check enable is cleared in the new MSR.
- R12: On `rfiStrobe`, `rfiSel` chooses a pair. `pcOut` becomes its saved address with bits 1:0 cleared. `msrOut` becomes its saved status ANDed with `~0x783F0000` for pair 0 in the classic model, and with all ones otherwise. `commit` pulses for one cycle.
- R13: `takeExc` with code 0 is ignored: no `commit`, no `vecErr` and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| takeExc | input | 1 | One-cycle strobe: take the exception described below |
| excCode | input | 5 | Exception kind |
| subCode | input | 2 | Program-check sub-cause |
| embMode | input | 1 | 1 selects the embedded exception model |
| curMsr | input | 32 | Current status word |
| curPc | input | 32 | Current instruction address |
| vecEntry | input | 32 | Vector table entry for this exception |
| vecPrefix | input | 32 | Vector base prefix |
| rfiStrobe | input | 1 | One-cycle strobe: return from interrupt |
| rfiSel | input | 2 | Save pair to return from |
| msrOut | output | 32 | Committed MSR |
| pcOut | output | 32 | Committed next fetch address |
| commit | output | 1 | State was committed on the last edge |
| vecErr | output | 1 | Last entry hit an undefined vector |
| halted | output | 1 | Checkstop state |
| saveAddrAll | output | 128 | Saved addresses of pairs 0..3, pair k at bits 32k+31:32k |
| saveStatAll | output | 128 | Saved statuses of pairs 0..3, same packing |

## Verification
Some properties are checked on every cycle:
- An entry MSR keeps nothing beyond the machine-check-enable and little-endian bits.
- A return always commits a word-aligned fetch address.
- An undefined vector raises the error flag without a commit.
- A code-0 strobe does nothing.
- A machine check with its enable clear leads to a sticky halt.
- The two strobes are never high together.

Other behaviour only shows up in the bench's scenarios, where a reference model tracks all four pairs: the exact saved-status values, the choice between faulting and next address, the pair routing and duplication in the embedded model, the FP drop rules, the power-save wake mark and the per-pair return masks.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int XLEN   = 32;
  localparam int NPAIR  = 4;
  localparam int PAIR_W = $clog2(NPAIR);
  localparam int CODE_W = 5;
  localparam int SUB_W  = 2;

  typedef enum logic [CODE_W-1:0] {
    EX_NONE  = 5'd0,  EX_CRIT  = 5'd1,  EX_MCHK  = 5'd2,  EX_DSTOR = 5'd3,
    EX_ISTOR = 5'd4,  EX_EXT   = 5'd5,  EX_ALIGN = 5'd6,  EX_PROG  = 5'd7,
    EX_FPU   = 5'd8,  EX_SYSC  = 5'd9,  EX_APU   = 5'd10, EX_DEC   = 5'd11,
    EX_FIT   = 5'd12, EX_WDOG  = 5'd13, EX_DEBUG = 5'd14, EX_RESET = 5'd15,
    EX_VECU  = 5'd16
  } excCode_e;

  localparam logic [SUB_W-1:0] PC_FP = 2'd0, PC_ILL = 2'd1, PC_PRIV = 2'd2, PC_TRAP = 2'd3;

  localparam logic [PAIR_W-1:0] PAIR_NORM = 0, PAIR_CRIT = 1, PAIR_MCHK = 2, PAIR_DBG = 3;

  // status word bit positions
  localparam int MSR_LE  = 0;
  localparam int MSR_FE1 = 8;
  localparam int MSR_FE0 = 11;
  localparam int MSR_ME  = 12;
  localparam int MSR_FP  = 13;
  localparam int MSR_ILE = 16;
  localparam int MSR_POW = 18;

  localparam logic [XLEN-1:0] MBZ_MASK = 32'h783F_0000;
  localparam logic [XLEN-1:0] ST_FP    = 32'h0010_0000;
  localparam logic [XLEN-1:0] ST_ILL   = 32'h0008_0000;
  localparam logic [XLEN-1:0] ST_PRIV  = 32'h0004_0000;
  localparam logic [XLEN-1:0] ST_TRAP  = 32'h0002_0000;
  localparam logic [XLEN-1:0] ST_SPLIT = 32'h0001_0000;
  localparam logic [XLEN-1:0] ST_WAKE  = 32'h0001_0000;

  typedef struct packed {
    logic              entryEn;
    logic              rfiEn;
    logic [PAIR_W-1:0] pairSel;
    logic              dupCrit;
    logic              faultAddr;
    logic [XLEN-1:0]   statOr;
    logic              maskStat;
    logic              clrMe;
    logic              setHalt;
    logic              vecBad;
    logic              fullRfiMask;
  } ctrlStrobe_t;
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic              takeExc,
  input  logic              rfiStrobe,
  input  logic              embMode,
  input  logic [CODE_W-1:0] excCode,
  input  logic [SUB_W-1:0]  subCode,
  input  logic              msrFp,
  input  logic              msrFe0,
  input  logic              msrFe1,
  input  logic              msrMe,
  input  logic              msrPow,
  input  logic [XLEN-1:0]   vecEntry,
  input  logic [PAIR_W-1:0] rfiSel,
  output ctrlStrobe_t       ctl
);
  logic fpOff, feSplit, dropIt, takeOk, vecAllOnes;

  always_comb begin
    fpOff      = !msrFp || (!msrFe0 && !msrFe1);
    feSplit    = msrFe0 ^ msrFe1;
    vecAllOnes = &vecEntry;
    dropIt     = 1'b0;
    ctl        = '0;
    ctl.maskStat = !embMode;
    ctl.pairSel  = PAIR_NORM;

    case (excCode_e'(excCode))
      EX_NONE: dropIt = 1'b1;
      EX_CRIT, EX_WDOG: if (embMode) ctl.pairSel = PAIR_CRIT;
      EX_MCHK: begin
        ctl.clrMe   = 1'b1;
        ctl.setHalt = !msrMe;
        if (embMode) begin
          ctl.pairSel = PAIR_MCHK;
          ctl.dupCrit = 1'b1;
        end
      end
      EX_DEBUG: if (embMode) begin
        ctl.pairSel = PAIR_DBG;
        ctl.dupCrit = 1'b1;
      end
      EX_ALIGN, EX_FPU, EX_APU, EX_VECU: ctl.faultAddr = 1'b1;
      EX_PROG: begin
        case (subCode)
          PC_FP: begin
            if (fpOff) dropIt = 1'b1;
            ctl.statOr    = feSplit ? (ST_FP | ST_SPLIT) : ST_FP;
            ctl.faultAddr = feSplit;
          end
          PC_ILL:  begin ctl.statOr = ST_ILL;  ctl.faultAddr = 1'b1; end
          PC_PRIV: begin ctl.statOr = ST_PRIV; ctl.faultAddr = 1'b1; end
          default: begin ctl.statOr = ST_TRAP; ctl.faultAddr = 1'b1; end
        endcase
      end
      EX_RESET: begin
        if (msrPow) ctl.statOr = ST_WAKE;
        else        ctl.clrMe  = 1'b1;
      end
      default: ;
    endcase

    takeOk      = takeExc && !dropIt;
    ctl.vecBad  = takeOk && vecAllOnes;
    ctl.entryEn = takeOk && !vecAllOnes;
    ctl.setHalt = ctl.setHalt && ctl.entryEn;
    ctl.rfiEn   = rfiStrobe && !takeExc;
    if (ctl.rfiEn) ctl.pairSel = rfiSel;
    ctl.fullRfiMask = embMode || (rfiSel != PAIR_NORM);
  end
endmodule

// File: rtl/exc_seq_dpath.sv
module exc_seq_dpath
  import exc_seq_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           ctl,
  input  logic [XLEN-1:0]       curMsr,
  input  logic [XLEN-1:0]       curPc,
  input  logic [XLEN-1:0]       vecEntry,
  input  logic [XLEN-1:0]       vecPrefix,
  output logic [XLEN-1:0]       msrOut,
  output logic [XLEN-1:0]       pcOut,
  output logic                  commit,
  output logic                  vecErr,
  output logic                  halted,
  output logic [NPAIR*XLEN-1:0] saveAddrAll,
  output logic [NPAIR*XLEN-1:0] saveStatAll
);
  logic [XLEN-1:0] pairAddr [NPAIR];
  logic [XLEN-1:0] pairStat [NPAIR];
  logic [XLEN-1:0] statSave, addrSave, entryMsr, rfiAddr, rfiMsr, rfiMask;

  always_comb begin
    statSave = (ctl.maskStat ? (curMsr & ~MBZ_MASK) : curMsr) | ctl.statOr;
    addrSave = ctl.faultAddr ? (curPc - XLEN'(4)) : curPc;
    entryMsr = '0;
    entryMsr[MSR_ME] = curMsr[MSR_ME] && !ctl.clrMe;
    entryMsr[MSR_LE] = curMsr[MSR_ILE];
    rfiMask  = ctl.fullRfiMask ? '1 : ~MBZ_MASK;
    rfiAddr  = pairAddr[ctl.pairSel] & ~XLEN'(3);
    rfiMsr   = pairStat[ctl.pairSel] & rfiMask;
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic hit;
    assign hit = ctl.entryEn &&
                 ((ctl.pairSel == PAIR_W'(g)) || (ctl.dupCrit && (PAIR_CRIT == PAIR_W'(g))));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pairAddr[g] <= '0;
        pairStat[g] <= '0;
      end else if (hit) begin
        pairAddr[g] <= addrSave;
        pairStat[g] <= statSave;
      end
    end
    assign saveAddrAll[g*XLEN +: XLEN] = pairAddr[g];
    assign saveStatAll[g*XLEN +: XLEN] = pairStat[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msrOut <= '0;
      pcOut  <= RESET_PC;
      commit <= 1'b0;
      vecErr <= 1'b0;
      halted <= 1'b0;
    end else begin
      commit <= ctl.entryEn || ctl.rfiEn;
      vecErr <= ctl.vecBad;
      if (ctl.setHalt) halted <= 1'b1;
      if (ctl.entryEn) begin
        msrOut <= entryMsr;
        pcOut  <= vecEntry | vecPrefix;
      end else if (ctl.rfiEn) begin
        msrOut <= rfiMsr;
        pcOut  <= rfiAddr;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  takeExc,
  input  logic [CODE_W-1:0]     excCode,
  input  logic [SUB_W-1:0]      subCode,
  input  logic                  embMode,
  input  logic [XLEN-1:0]       curMsr,
  input  logic [XLEN-1:0]       curPc,
  input  logic [XLEN-1:0]       vecEntry,
  input  logic [XLEN-1:0]       vecPrefix,
  input  logic                  rfiStrobe,
  input  logic [PAIR_W-1:0]     rfiSel,
  output logic [XLEN-1:0]       msrOut,
  output logic [XLEN-1:0]       pcOut,
  output logic                  commit,
  output logic                  vecErr,
  output logic                  halted,
  output logic [NPAIR*XLEN-1:0] saveAddrAll,
  output logic [NPAIR*XLEN-1:0] saveStatAll
);
  ctrlStrobe_t ctl;

  exc_seq_ctrl i_ctrl (
    .takeExc   (takeExc),
    .rfiStrobe (rfiStrobe),
    .embMode   (embMode),
    .excCode   (excCode),
    .subCode   (subCode),
    .msrFp     (curMsr[MSR_FP]),
    .msrFe0    (curMsr[MSR_FE0]),
    .msrFe1    (curMsr[MSR_FE1]),
    .msrMe     (curMsr[MSR_ME]),
    .msrPow    (curMsr[MSR_POW]),
    .vecEntry  (vecEntry),
    .rfiSel    (rfiSel),
    .ctl       (ctl)
  );

  exc_seq_dpath #(.RESET_PC(RESET_PC)) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .curMsr      (curMsr),
    .curPc       (curPc),
    .vecEntry    (vecEntry),
    .vecPrefix   (vecPrefix),
    .msrOut      (msrOut),
    .pcOut       (pcOut),
    .commit      (commit),
    .vecErr      (vecErr),
    .halted      (halted),
    .saveAddrAll (saveAddrAll),
    .saveStatAll (saveStatAll)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              takeExc,
  input logic              rfiStrobe,
  input logic [CODE_W-1:0] excCode,
  input logic              curMsrMe,
  input logic [XLEN-1:0]   vecEntry,
  input logic [XLEN-1:0]   msrOut,
  input logic [1:0]        pcLow,
  input logic              commit,
  input logic              vecErr,
  input logic              halted
);
  localparam logic [XLEN-1:0] KEEP = (XLEN'(1) << MSR_ME) | (XLEN'(1) << MSR_LE);

  p_excl_strobes_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(takeExc && rfiStrobe));

  p_vec_undef_r3: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && excCode != EX_NONE && excCode != EX_PROG && (&vecEntry))
    |=> (vecErr && !commit));

  p_entry_msr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (commit && $past(takeExc)) |-> ((msrOut & ~KEEP) == '0));

  p_mchk_halt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && excCode == EX_MCHK && !curMsrMe && !(&vecEntry))
    |=> (halted && !msrOut[MSR_ME]));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  p_rfi_align_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rfiStrobe && !takeExc) |=> (commit && pcLow == 2'b00));

  p_code_none_r13: assert property (@(posedge clk) disable iff (!rstN)
    (takeExc && excCode == EX_NONE) |=> (!commit && !vecErr));
endmodule

bind exc_entry_seq exc_entry_seq_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .takeExc   (takeExc),
  .rfiStrobe (rfiStrobe),
  .excCode   (excCode),
  .curMsrMe  (curMsr[12]),
  .vecEntry  (vecEntry),
  .msrOut    (msrOut),
  .pcLow     (pcOut[1:0]),
  .commit    (commit),
  .vecErr    (vecErr),
  .halted    (halted)
);

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         takeExc = 1'b0;
  logic [4:0]   excCode = '0;
  logic [1:0]   subCode = '0;
  logic         embMode = 1'b0;
  logic [31:0]  curMsr = '0, curPc = '0, vecEntry = '0, vecPrefix = '0;
  logic         rfiStrobe = 1'b0;
  logic [1:0]   rfiSel = '0;
  logic [31:0]  msrOut, pcOut;
  logic         commit, vecErr, halted;
  logic [127:0] saveAddrAll, saveStatAll;

  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam logic [31:0] MBZ    = 32'h783F_0000;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rstN(rstN), .takeExc(takeExc), .excCode(excCode), .subCode(subCode),
    .embMode(embMode), .curMsr(curMsr), .curPc(curPc), .vecEntry(vecEntry),
    .vecPrefix(vecPrefix), .rfiStrobe(rfiStrobe), .rfiSel(rfiSel),
    .msrOut(msrOut), .pcOut(pcOut), .commit(commit), .vecErr(vecErr), .halted(halted),
    .saveAddrAll(saveAddrAll), .saveStatAll(saveStatAll)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] mAddr [4];
  logic [31:0] mStat [4];
  logic [31:0] mMsr, mPc;
  logic        mHalt, eCommit, eVecErr;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string req);
    chk(req, "commit", 32'(commit), 32'(eCommit));
    chk(req, "vecErr", 32'(vecErr), 32'(eVecErr));
    chk(req, "halted", 32'(halted), 32'(mHalt));
    chk(req, "msrOut", msrOut, mMsr);
    chk(req, "pcOut",  pcOut,  mPc);
    for (int k = 0; k < 4; k++) begin
      chk(req, $sformatf("addr pair%0d", k), saveAddrAll[k*32 +: 32], mAddr[k]);
      chk(req, $sformatf("stat pair%0d", k), saveStatAll[k*32 +: 32], mStat[k]);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 4; k++) begin mAddr[k] = '0; mStat[k] = '0; end
    mMsr = '0; mPc = RST_PC; mHalt = 1'b0; eCommit = 1'b0; eVecErr = 1'b0;
  endtask

  task automatic doEntry(input string req, input logic [4:0] code, input logic [1:0] sub,
                         input logic [31:0] m, input logic [31:0] pc, input logic [31:0] vec,
                         input logic [31:0] pre, input logic emb);
    logic drop, fault, dup, clrMe, stop;
    int sel;
    logic [31:0] orb, st;
    logic fpOn, fe0, fe1;
    fpOn = m[13]; fe0 = m[11]; fe1 = m[8];
    drop = 0; fault = 0; dup = 0; clrMe = 0; stop = 0; sel = 0; orb = '0;
    if (code == 5'd0) drop = 1;
    else if (code == 5'd1 || code == 5'd13) sel = emb ? 1 : 0;
    else if (code == 5'd2) begin clrMe = 1; stop = !m[12]; if (emb) begin sel = 2; dup = 1; end end
    else if (code == 5'd14) begin if (emb) begin sel = 3; dup = 1; end end
    else if (code == 5'd6 || code == 5'd8 || code == 5'd10 || code == 5'd16) fault = 1;
    else if (code == 5'd7) begin
      if (sub == 2'd0) begin
        if (!fpOn || (!fe0 && !fe1)) drop = 1;
        orb = 32'h0010_0000 | ((fe0 != fe1) ? 32'h0001_0000 : 32'h0);
        fault = (fe0 != fe1);
      end else begin
        fault = 1;
        orb = (sub == 2'd1) ? 32'h0008_0000 : (sub == 2'd2) ? 32'h0004_0000 : 32'h0002_0000;
      end
    end else if (code == 5'd15) begin
      if (m[18]) orb = 32'h0001_0000; else clrMe = 1;
    end
    eCommit = 0; eVecErr = 0;
    if (!drop) begin
      if (vec == 32'hFFFF_FFFF) eVecErr = 1;
      else begin
        eCommit = 1;
        st = (emb ? m : (m & ~MBZ)) | orb;
        mAddr[sel] = fault ? pc - 32'd4 : pc;
        mStat[sel] = st;
        if (dup) begin mAddr[1] = mAddr[sel]; mStat[1] = st; end
        mMsr = '0;
        mMsr[12] = m[12] && !clrMe;
        mMsr[0]  = m[16];
        mPc = vec | pre;
        if (stop) mHalt = 1;
      end
    end
    @(negedge clk);
    excCode = code; subCode = sub; curMsr = m; curPc = pc; vecEntry = vec;
    vecPrefix = pre; embMode = emb; takeExc = 1'b1;
    @(negedge clk);
    takeExc = 1'b0;
    compareAll(req);
  endtask

  task automatic doRfi(input string req, input logic [1:0] kind, input logic emb);
    logic [31:0] mask;
    mask = (emb || kind != 2'd0) ? 32'hFFFF_FFFF : ~MBZ;
    eCommit = 1; eVecErr = 0;
    mPc  = mAddr[kind] & ~32'd3;
    mMsr = mStat[kind] & mask;
    @(negedge clk);
    rfiSel = kind; embMode = emb; rfiStrobe = 1'b1;
    @(negedge clk);
    rfiStrobe = 1'b0;
    compareAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rm, rv;
    modelReset();
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    compareAll("R1");              // during reset
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");              // after release

    // R13: code 0 ignored
    doEntry("R13", 5'd0, 2'd0, 32'hFFFF_FFFF, 32'h2000, 32'h700, 32'h0, 1'b0);
    // R2: plain entry with prefix
    doEntry("R2", 5'd11, 2'd0, 32'h0000_1000, 32'h2000, 32'h900, 32'hFFF0_0000, 1'b0);
    // R3: undefined vector
    doEntry("R3", 5'd5, 2'd0, 32'h0000_1000, 32'h3000, 32'hFFFF_FFFF, 32'h0, 1'b0);
    // R4: masking in both models
    doEntry("R4", 5'd11, 2'd0, 32'hFFFF_FFFF, 32'h4000, 32'h900, 32'h0, 1'b0);
    doEntry("R4", 5'd11, 2'd0, 32'hFFFF_FFFF, 32'h4000, 32'h900, 32'h0, 1'b1);
    // R5: little-endian from ILE
    doEntry("R5", 5'd9, 2'd0, 32'h0001_1000, 32'h5000, 32'hC00, 32'h0, 1'b0);
    // R6: faulting vs next address
    doEntry("R6", 5'd6, 2'd0, 32'h0, 32'h6000, 32'h600, 32'h0, 1'b0);
    doEntry("R6", 5'd16, 2'd0, 32'h0, 32'h6100, 32'hF20, 32'h0, 1'b0);
    doEntry("R6", 5'd9, 2'd0, 32'h0, 32'h6200, 32'hC00, 32'h0, 1'b0);
    // R7: program causes
    for (int s = 1; s < 4; s++)
      doEntry("R7", 5'd7, 2'(s), 32'h0000_1000, 32'h7000 + 32'(s*16), 32'h700, 32'h0, 1'b0);
    // R8: FP drop and split modes
    doEntry("R8", 5'd7, 2'd0, 32'h0000_0900, 32'h8000, 32'hFFFF_FFFF, 32'h0, 1'b0); // FP off
    doEntry("R8", 5'd7, 2'd0, 32'h0000_2000, 32'h8000, 32'h700, 32'h0, 1'b0);       // modes 0
    doEntry("R8", 5'd7, 2'd0, 32'h0000_2800, 32'h8100, 32'h700, 32'h0, 1'b0);       // split
    doEntry("R8", 5'd7, 2'd0, 32'h0000_2900, 32'h8200, 32'h700, 32'h0, 1'b0);       // both 1
    // R10: pair routing in embedded model
    doEntry("R10", 5'd1, 2'd0, 32'h0000_1000, 32'hA000, 32'h100, 32'h0, 1'b1);
    doEntry("R10", 5'd13, 2'd0, 32'h0000_1000, 32'hA100, 32'h120, 32'h0, 1'b1);
    doEntry("R10", 5'd14, 2'd0, 32'h0000_1000, 32'hA200, 32'h140, 32'h0, 1'b1);
    doEntry("R10", 5'd2, 2'd0, 32'h0000_1000, 32'hA300, 32'h160, 32'h0, 1'b1);
    doEntry("R10", 5'd1, 2'd0, 32'h0000_1000, 32'hA400, 32'h100, 32'h0, 1'b0);
    // R11: reset with and without power-save
    doEntry("R11", 5'd15, 2'd0, 32'h0004_1000, 32'hB000, 32'h100, 32'h0, 1'b0);
    doEntry("R11", 5'd15, 2'd0, 32'h0000_1000, 32'hB100, 32'h100, 32'h0, 1'b0);
    // R12: returns from each pair, both models
    doEntry("R12", 5'd11, 2'd0, 32'h7FFF_FFFF, 32'hC003, 32'h900, 32'h0, 1'b1);
    doRfi("R12", 2'd0, 1'b0);
    doRfi("R12", 2'd0, 1'b1);
    for (int k = 1; k < 4; k++) doRfi("R12", 2'(k), 1'b0);
    // R9: machine check with enable clear halts (classic model)
    doEntry("R9", 5'd2, 2'd0, 32'h0000_0000, 32'hD000, 32'h200, 32'h0, 1'b0);
    doEntry("R9", 5'd11, 2'd0, 32'h0000_1000, 32'hD100, 32'h900, 32'h0, 1'b0);

    // constrained random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) doRfi("R12", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      else begin
        rm = $urandom;
        rv = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : ($urandom & 32'h0000_FFF0);
        doEntry("R2", 5'($urandom_range(0, 20)), 2'($urandom_range(0, 3)), rm, $urandom,
                rv, $urandom & 32'hFFF0_0000, 1'($urandom_range(0, 1)));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule